// File: doc/BRIEF.md
# Detail Access Trace Line Generator with Conditional Timestamps

This block watches the data and vector accesses of a processor and, for each one, writes a 64-bit trace line into an external trace store. A line carries the full 32-bit data value, an info byte giving the access size and whether it was a read or a write, and the 24-bit access address. An entry counter advances by two for every line written, so a debugger can tell how much of the store has been filled.

When timestamps are enabled, an access may earn a second line. That line holds the value of a free-running, saturating timestamp counter, an info byte marked as a timestamp, and the program counter if one is valid in the decision cycle. The block only writes this line if the cycle after the access is free of accesses. A back-to-back access takes that write slot and suppresses the timestamp. The timestamp counter is cleared only when a timestamp line is really written, so each stored timestamp is the time since the previous stored one.

Top module: `detail_trace`

## Requirements
- R1: One cycle after a cycle with `acc_valid` high, `wr_en` is high and `wr_line` holds the access data in bits [63:32] and the access address in bits [23:0].
- R2: On an access line, the info byte `wr_line[31:24]` is {write flag at bit 7, 0 at bit 6, size at bits [5:4], 0 in bits [3:0]}, so its bit 1 is 0.
- R3: `entry_cnt` rises by 2 in the same cycle that `wr_en` is high and holds its value in every other cycle.
- R4: If `ts_en` is high with an access and the next cycle has no access, then the cycle after that shows a timestamp line, so the entry takes two lines and adds 4 to `entry_cnt`.
- R5: If an access follows the previous access in the very next cycle, no timestamp line is written for the earlier access. Only the new access line is written.
- R6: A timestamp line has info byte bit 1 set, bit 0 equal to `pc_valid` in the decision cycle (the cycle after the access), bits [7:2] zero, and bits [23:0] equal to `pc_addr` when that flag is set and zero otherwise.
- R7: The timestamp field `wr_line[63:32]` holds the counter value zero-extended. The counter advances by one every cycle and is cleared only by a written timestamp line, so a stored value equals the number of clock edges since the previous timestamp write, or since reset.
- R8: The timestamp counter stops at its all-ones value and does not wrap.
- R9: No timestamp line follows an access made while `ts_en` was low.
- R10: While reset is active and after it is released, `wr_en` is 0 and `entry_cnt` is 0.
- R11: `entry_cnt` wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A data or vector access occurs this cycle |
| acc_addr | input | 24 | Access address |
| acc_data | input | 32 | Access data |
| acc_size | input | 2 | Access size code |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| pc_valid | input | 1 | `pc_addr` is valid this cycle |
| pc_addr | input | 24 | Program counter value |
| ts_en | input | 1 | Timestamps enabled for an access in this cycle |
| wr_en | output | 1 | Trace line write strobe |
| wr_line | output | 64 | Trace line to be written |
| entry_cnt | output | CNT_W | Entry counter, in half-line units of two per line |

## Verification
The bench builds the block with a 4-bit timestamp counter and a 6-bit entry counter. With these widths, saturation is reached after fifteen idle cycles and the entry counter wraps after 32 lines. Both corners therefore occur many times in a few thousand cycles of mixed traffic. Directed phases cover isolated and back-to-back accesses, a timestamp with and without a valid program counter, and short and long gaps between timestamp lines.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int ADDR_W      = 24;
  localparam int DATA_W      = 32;
  localparam int INFO_W      = 8;
  localparam int LINE_W      = DATA_W + INFO_W + ADDR_W;
  localparam int INFO_TS_BIT = 1;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [INFO_W-1:0] info;
    logic [ADDR_W-1:0] addr;
  } line_t;

  function automatic logic [INFO_W-1:0] acc_info(input logic wr, input logic [1:0] sz);
    return {wr, 1'b0, sz, 4'b0000};
  endfunction

  function automatic logic [INFO_W-1:0] ts_info(input logic pc_flag);
    return {6'b000000, 1'b1, pc_flag};
  endfunction
endpackage

// File: rtl/trc_ts_counter.sv
module trc_ts_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] val
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr)              cnt_d = '0;
    else if (cnt_q != MAX) cnt_d = cnt_q + 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign val = cnt_q;
endmodule

// File: rtl/trc_entry_counter.sv
module trc_entry_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] STEP = W'(2);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc) cnt_d = cnt_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/trc_line_build.sv
module trc_line_build
  import trace_pkg::*;
#(
  parameter int TS_W = 16
) (
  input  logic              sel_ts,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  input  logic [1:0]        acc_size,
  input  logic              acc_write,
  input  logic [TS_W-1:0]   ts_val,
  input  logic              pc_valid,
  input  logic [ADDR_W-1:0] pc_addr,
  output line_t             line
);
  always_comb begin
    if (sel_ts) begin
      line.data = DATA_W'(ts_val);
      line.info = ts_info(pc_valid);
      line.addr = pc_valid ? pc_addr : '0;
    end else begin
      line.data = acc_data;
      line.info = acc_info(acc_write, acc_size);
      line.addr = acc_addr;
    end
  end
endmodule

// File: rtl/detail_trace.sv
module detail_trace
  import trace_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [23:0]       acc_addr,
  input  logic [31:0]       acc_data,
  input  logic [1:0]        acc_size,
  input  logic              acc_write,
  input  logic              pc_valid,
  input  logic [23:0]       pc_addr,
  input  logic              ts_en,
  output logic              wr_en,
  output logic [63:0]       wr_line,
  output logic [CNT_W-1:0]  entry_cnt
);
  // Timestamp decision waits one cycle to see whether the slot is free.
  logic            pend_q, pend_d;
  logic            sel_ts;
  logic            wr_d, wr_q;
  line_t           line_d, line_q;
  logic [TS_W-1:0] ts_val;

  always_comb begin
    sel_ts = pend_q && !acc_valid;
    wr_d   = acc_valid || sel_ts;
    pend_d = acc_valid && ts_en;
  end

  trc_ts_counter #(.W(TS_W)) u_ts (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sel_ts),
    .val   (ts_val)
  );

  trc_line_build #(.TS_W(TS_W)) u_build (
    .sel_ts    (sel_ts),
    .acc_addr  (acc_addr),
    .acc_data  (acc_data),
    .acc_size  (acc_size),
    .acc_write (acc_write),
    .ts_val    (ts_val),
    .pc_valid  (pc_valid),
    .pc_addr   (pc_addr),
    .line      (line_d)
  );

  trc_entry_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (wr_d),
    .cnt   (entry_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      wr_q   <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    line_q <= '0;
    else if (wr_d) line_q <= line_d;
  end

  assign wr_en   = wr_q;
  assign wr_line = line_q;
endmodule

// File: rtl/trace_chk.sv
module trace_chk #(
  parameter int TS_W  = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             ts_en,
  input logic             wr_en,
  input logic [63:0]      wr_line,
  input logic [CNT_W-1:0] entry_cnt,
  input logic [TS_W-1:0]  ts_val
);
  localparam logic [TS_W-1:0] TS_MAX = '1;

  logic is_ts_line;
  assign is_ts_line = wr_en && wr_line[25];

  p_line_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (wr_en && !wr_line[25]));

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (entry_cnt == CNT_W'($past(entry_cnt) + CNT_W'(2))));

  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> $stable(entry_cnt));

  p_ts_needs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_ts_line |-> !$past(acc_valid));

  p_ts_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_ts_line |-> $past(ts_en, 2));

  p_ts_info_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_ts_line |-> (wr_line[31:26] == 6'd0));

  p_ts_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_ts_line |-> (ts_val == '0));

  p_ts_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_val == TS_MAX) |=> (ts_val == TS_MAX || ts_val == '0));
endmodule

bind detail_trace trace_chk #(.TS_W(TS_W), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .ts_en     (ts_en),
  .wr_en     (wr_en),
  .wr_line   (wr_line),
  .entry_cnt (entry_cnt),
  .ts_val    (ts_val)
);

// File: tb/detail_trace_tb_top.sv
module detail_trace_tb_top;
  localparam int TS_W  = 4;
  localparam int CNT_W = 6;
  localparam int TS_MAXV  = (1 << TS_W) - 1;
  localparam int CNT_MOD  = 1 << CNT_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             acc_valid, acc_write, pc_valid, ts_en;
  logic [23:0]      acc_addr, pc_addr;
  logic [31:0]      acc_data;
  logic [1:0]       acc_size;
  logic             wr_en;
  logic [63:0]      wr_line;
  logic [CNT_W-1:0] entry_cnt;

  always #4 clk = ~clk;

  detail_trace #(.TS_W(TS_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_data(acc_data), .acc_size(acc_size), .acc_write(acc_write),
    .pc_valid(pc_valid), .pc_addr(pc_addr), .ts_en(ts_en),
    .wr_en(wr_en), .wr_line(wr_line), .entry_cnt(entry_cnt)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // reference model state
  bit m_pend = 0;
  int m_tsc  = 0;
  int m_cnt  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit av, input logic [23:0] a, input logic [31:0] d,
                      input logic [1:0] sz, input bit w, input bit pv,
                      input logic [23:0] pa, input bit te);
    bit e_wr, e_ts, e_supp, e_sat, wrapped;
    logic [63:0] e_line;
    acc_valid = av; acc_addr = a; acc_data = d; acc_size = sz;
    acc_write = w; pc_valid = pv; pc_addr = pa; ts_en = te;
    e_wr = 0; e_ts = 0; e_sat = 0; wrapped = 0; e_line = '0;
    e_supp = m_pend && av;
    if (av) begin
      e_wr = 1;
      e_line = {d, w, 1'b0, sz, 4'b0000, a};
    end else if (m_pend) begin
      e_wr = 1; e_ts = 1; e_sat = (m_tsc == TS_MAXV);
      e_line = {32'(m_tsc), 6'b0, 1'b1, pv, (pv ? pa : 24'h0)};
    end
    if (e_wr) begin
      m_cnt = m_cnt + 2;
      if (m_cnt >= CNT_MOD) begin m_cnt = m_cnt - CNT_MOD; wrapped = 1; end
    end
    if (e_ts)                m_tsc = 0;
    else if (m_tsc < TS_MAXV) m_tsc = m_tsc + 1;
    m_pend = av && te;
    @(negedge clk);
    if (e_ts)        chk(wr_en == e_wr, "R4", "ts line strobe", 64'(wr_en), 64'(e_wr));
    else if (e_wr)   chk(wr_en == e_wr, "R1", "access line strobe", 64'(wr_en), 64'(e_wr));
    else if (e_supp) chk(wr_en == e_wr, "R5", "suppressed slot", 64'(wr_en), 64'(e_wr));
    else             chk(wr_en == e_wr, "R9", "idle slot", 64'(wr_en), 64'(e_wr));
    if (e_wr && !e_ts) begin
      chk({wr_line[63:32], wr_line[23:0]} == {e_line[63:32], e_line[23:0]}, "R1",
          "access data/addr", wr_line, e_line);
      chk(wr_line[31:24] == e_line[31:24], "R2", "access info", 64'(wr_line[31:24]),
          64'(e_line[31:24]));
    end
    if (e_ts) begin
      if (e_sat) chk(wr_line[63:32] == e_line[63:32], "R8", "saturated stamp",
                     64'(wr_line[63:32]), 64'(e_line[63:32]));
      else       chk(wr_line[63:32] == e_line[63:32], "R7", "stamp value",
                     64'(wr_line[63:32]), 64'(e_line[63:32]));
      chk(wr_line[31:0] == e_line[31:0], "R6", "ts info/pc", 64'(wr_line[31:0]),
          64'(e_line[31:0]));
    end
    if (wrapped) chk(int'(entry_cnt) == m_cnt, "R11", "counter wrap", 64'(entry_cnt), 64'(m_cnt));
    else         chk(int'(entry_cnt) == m_cnt, "R3", "entry counter", 64'(entry_cnt), 64'(m_cnt));
  endtask

  task automatic idle(input int n, input bit pv, input logic [23:0] pa);
    for (int i = 0; i < n; i++) step(0, 24'h0, 32'h0, 2'd0, 0, pv, pa, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    acc_valid = 0; acc_addr = '0; acc_data = '0; acc_size = '0;
    acc_write = 0; pc_valid = 0; pc_addr = '0; ts_en = 0;
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0 && entry_cnt == '0, "R10", "in reset", {wr_en, 57'(entry_cnt)}, 64'h0);
    rst_n = 1'b1;
    chk(wr_en == 1'b0 && entry_cnt == '0, "R10", "after release", {wr_en, 57'(entry_cnt)}, 64'h0);

    // timestamps off: isolated and back-to-back accesses
    step(1, 24'h12_3456, 32'hDEAD_BEEF, 2'd2, 1, 0, 24'h0, 0);
    idle(2, 0, 24'h0);
    step(1, 24'hFF_0001, 32'h0000_00A5, 2'd0, 0, 1, 24'h11_1111, 0);
    step(1, 24'h00_0002, 32'h1234_5678, 2'd1, 1, 0, 24'h0, 0);
    idle(3, 0, 24'h0);

    // timestamp with PC valid, then without
    step(1, 24'hAB_CDEF, 32'hCAFE_F00D, 2'd3, 0, 0, 24'h0, 1);
    step(0, 24'h0, 32'h0, 2'd0, 0, 1, 24'h77_6655, 0);
    idle(1, 0, 24'h0);
    step(1, 24'h01_0203, 32'h0405_0607, 2'd2, 1, 0, 24'h0, 1);
    step(0, 24'h0, 32'h0, 2'd0, 0, 0, 24'h99_9999, 0);

    // back-to-back with timestamps on: only the last gets a stamp
    for (int i = 0; i < 4; i++)
      step(1, 24'(24'h20_0000 + i), 32'(i * 3), 2'(i), i[0], 0, 24'h0, 1);
    idle(2, 1, 24'h3C_3C3C);

    // long gap to saturate the counter
    idle(20, 0, 24'h0);
    step(1, 24'h55_5555, 32'h5555_AAAA, 2'd1, 0, 0, 24'h0, 1);
    idle(2, 0, 24'h0);
    // short gap between stamps
    step(1, 24'h66_0000, 32'h0, 2'd0, 0, 0, 24'h0, 1);
    idle(2, 1, 24'h12_0000);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      bit av;
      av = ($urandom_range(0, 99) < 45);
      step(av, 24'($urandom), $urandom, 2'($urandom), 1'($urandom), 1'($urandom),
           24'($urandom), ($urandom_range(0, 3) != 0));
      if (($urandom_range(0, 199)) == 0) idle(18, 0, 24'h0);
    end
    idle(3, 0, 24'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule